// File: doc/BRIEF.md
# Holdover Mode Controller

This block is the supervisory state machine that sits beside a digital phase-locked loop. It chooses whether the loop tracks its reference, coasts on a stored frequency, or runs open from the master clock. It also decides when the output drivers may be enabled and when the lock flag is shown. The inputs are a freerun request, a reference pick, a disrupted flag from the reference monitor, the loop's phase error and the oscillator's current frequency word. The block uses these to step between five states: power-up hold-off, freerun, normal tracking, automatic holdover, and a one-cycle phase-offset capture.

While the loop tracks with lock shown, the block samples the oscillator frequency word at a fixed interval. Each sample goes into one of two slots, and the slots are used in turn. When holdover begins, the block presents the older of the two samples as the coasting frequency. A reference that failed just before the switch therefore cannot spoil the value. The lock flag needs an unbroken run of in-window phase error before it rises. It stays up for a grace interval after holdover begins, and it drops at once in freerun. A rate input selects the narrow loop bandwidth for the slowest reference rate.

All timing intervals are parameters counted in clock cycles. The oscillator itself is outside this block.

Top module: `hoc_ctrl`

## Requirements
- R1: While rst_n is low, and for RST_TICKS cycles after it rises, state_o is 0 (reset) and out_en is 0. After that, state_o becomes 3 (holdover) and out_en is 1.
- R2: From any state other than reset, mode_free=1 moves state_o to 1 (freerun) on the next cycle. The state stays there whatever the reference inputs do. lock is 0 in every cycle where state_o is 1. When mode_free returns to 0, the next state is holdover.
- R3: In holdover with ref_bad=0, the next state is 4 (correction). Correction lasts exactly one cycle with capture_pulse=1 and is followed by 2 (normal). capture_pulse is 0 in every other state.
- R4: In normal, ref_bad=1 or a toggle of ref_pick moves the state to holdover on the next cycle.
- R5: While state is normal and lock is 1, dco_word is written every SLOT_TICKS cycles into two slots used in turn. On entry to holdover, hold_word takes the older slot (the one written one interval before the newest) and then holds its value for the whole of holdover.
- R6: If lock is 1 when holdover is entered, it stays 1 for GRACE_TICKS cycles of holdover and then drops to 0.
- R7: The phase error is in window when |phase_err| <= LOCK_WIN, with the bound inclusive. In normal, lock rises after QUAL_TICKS consecutive in-window cycles. One out-of-window cycle clears lock and restarts the count.
- R8: bw_narrow follows ref_low_rate (1 = slowest reference rate) with one cycle of delay. 1 selects the narrow loop bandwidth.
- R9: A ref_pick change gives a single-cycle change event. A held new ref_pick value does not keep the state in holdover, so the state moves to correction on the following cycle.
- R10: When lock is 1 and the phase error stays in window, lock stays 1 across a reference switch through holdover and correction back to normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_free | input | 1 | 1 forces freerun, 0 allows tracking with automatic holdover |
| ref_pick | input | 1 | Selects which of two references the loop follows |
| ref_bad | input | 1 | Selected reference disrupted |
| ref_low_rate | input | 1 | Detected rate is the slowest reference rate |
| phase_err | input | PE_W | Signed phase detector output |
| dco_word | input | FW | Current oscillator frequency word |
| state_o | output | 3 | 0 reset, 1 freerun, 2 normal, 3 holdover, 4 correction |
| hold_word | output | FW | Frequency word applied during holdover |
| capture_pulse | output | 1 | Strobe telling the phase corrector to capture the offset |
| out_en | output | 1 | Output driver enable |
| lock | output | 1 | Lock indication |
| bw_narrow | output | 1 | 1 selects the narrow loop bandwidth |

## Verification
Some properties are checked by the assertions on every cycle. A forced freerun lands in freerun. A holdover with a clean reference steps into correction, and correction never lasts two cycles. Normal is reached only through correction, a reference toggle always leaves normal, and hold_word never moves during holdover. Lock rises only out of normal and falls after any excursion from the window. The bench's scenarios are what show the interval lengths: the reset hold-off, the qualify run, the grace period, and the pick of the older frequency slot after three sampling intervals. They also cover the inclusive window bound and the lock held through a hitless switch.

// File: rtl/hoc_pkg.sv
package hoc_pkg;
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_FREE   = 3'd1,
    ST_NORMAL = 3'd2,
    ST_HOLD   = 3'd3,
    ST_TIE    = 3'd4
  } hoc_state_e;
endpackage

// File: rtl/hoc_fsm.sv
module hoc_fsm
  import hoc_pkg::*;
#(
  parameter int RST_TICKS = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_free,
  input  logic       ref_pick,
  input  logic       ref_bad,
  output hoc_state_e state,
  output logic       hold_entry
);
  localparam int RCW = $clog2(RST_TICKS + 1);
  localparam logic [RCW-1:0] RST_LAST = RCW'(RST_TICKS - 1);

  hoc_state_e     state_nxt;
  logic [RCW-1:0] rst_cnt;
  logic           pick_q;
  logic           pick_chg;

  assign pick_chg = ref_pick ^ pick_q;

  always_comb begin
    state_nxt = state;
    if (state == ST_RESET) begin
      if (rst_cnt == RST_LAST) state_nxt = ST_HOLD;
    end else if (mode_free) begin
      state_nxt = ST_FREE;
    end else begin
      case (state)
        ST_FREE:   state_nxt = ST_HOLD;
        ST_HOLD:   if (!ref_bad) state_nxt = ST_TIE;
        ST_TIE:    state_nxt = ST_NORMAL;
        ST_NORMAL: if (ref_bad || pick_chg) state_nxt = ST_HOLD;
        default:   state_nxt = ST_HOLD;
      endcase
    end
  end

  assign hold_entry = (state_nxt == ST_HOLD) && (state != ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RESET;
      rst_cnt <= '0;
      pick_q  <= 1'b0;
    end else begin
      state  <= state_nxt;
      pick_q <= ref_pick;
      if ((state == ST_RESET) && (rst_cnt != RST_LAST)) rst_cnt <= rst_cnt + 1'b1;
    end
  end

  AST_FREE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_free && state != ST_RESET) |=> state == ST_FREE); // R2
  AST_HOLD_TO_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !ref_bad && !mode_free) |=> state == ST_TIE); // R3
  AST_TIE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TIE) |=> state != ST_TIE); // R3
  AST_NORMAL_VIA_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_NORMAL && state != ST_TIE) |=> state != ST_NORMAL); // R3
  AST_PICK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && pick_chg && !mode_free) |=> state == ST_HOLD); // R4
endmodule

// File: rtl/hoc_lock_qual.sv
module hoc_lock_qual
  import hoc_pkg::*;
#(
  parameter int PE_W        = 16,
  parameter int LOCK_WIN    = 64,
  parameter int QUAL_TICKS  = 1000,
  parameter int GRACE_TICKS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hoc_state_e        state,
  input  logic [PE_W-1:0]   phase_err,
  output logic              lock
);
  localparam int QCW = $clog2(QUAL_TICKS + 1);
  localparam int GCW = $clog2(GRACE_TICKS + 1);
  localparam logic [QCW-1:0]  QUAL_LAST  = QCW'(QUAL_TICKS - 1);
  localparam logic [GCW-1:0]  GRACE_LAST = GCW'(GRACE_TICKS - 1);
  localparam logic [PE_W-1:0] WIN_V      = PE_W'(LOCK_WIN);

  logic [PE_W-1:0] err_mag;
  logic            in_win;
  logic [QCW-1:0]  qual_cnt;
  logic [GCW-1:0]  grace_cnt;
  logic            lock_q;

  assign err_mag = phase_err[PE_W-1] ? (~phase_err + 1'b1) : phase_err;
  assign in_win  = (err_mag <= WIN_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      qual_cnt  <= '0;
      grace_cnt <= '0;
    end else begin
      if (state != ST_HOLD) grace_cnt <= '0;
      case (state)
        ST_NORMAL: begin
          if (!in_win) begin
            lock_q   <= 1'b0;
            qual_cnt <= '0;
          end else if (qual_cnt == QUAL_LAST) begin
            lock_q <= 1'b1;
          end else begin
            qual_cnt <= qual_cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          qual_cnt <= '0;
          if (grace_cnt == GRACE_LAST) lock_q <= 1'b0;
          else grace_cnt <= grace_cnt + 1'b1;
        end
        ST_TIE: ;
        default: begin
          lock_q   <= 1'b0;
          qual_cnt <= '0;
        end
      endcase
    end
  end

  assign lock = lock_q && (state != ST_FREE);

  AST_LOCK_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(state) == ST_NORMAL); // R7
  AST_EXCURSION_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && !in_win) |=> !lock_q); // R7
endmodule

// File: rtl/hoc_freq_mem.sv
module hoc_freq_mem
  import hoc_pkg::*;
#(
  parameter int FW         = 32,
  parameter int SLOT_TICKS = 2600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hoc_state_e    state,
  input  logic          lock,
  input  logic          hold_entry,
  input  logic [FW-1:0] dco_word,
  output logic [FW-1:0] hold_word
);
  localparam int NSLOT = 2;
  localparam int TCW   = $clog2(SLOT_TICKS + 1);
  localparam logic [TCW-1:0] SLOT_LAST = TCW'(SLOT_TICKS - 1);

  logic [TCW-1:0] slot_tmr;
  logic           sample_en;
  logic           sample_tick;
  logic           wr_ptr;
  logic [FW-1:0]  slot_q [NSLOT];

  assign sample_en   = (state == ST_NORMAL) && lock;
  assign sample_tick = sample_en && (slot_tmr == SLOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_tmr <= '0;
      wr_ptr   <= 1'b0;
    end else begin
      if (!sample_en || sample_tick) slot_tmr <= '0;
      else slot_tmr <= slot_tmr + 1'b1;
      if (sample_tick) wr_ptr <= ~wr_ptr;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic slot_we;
    assign slot_we = sample_tick && (wr_ptr == 1'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (slot_we) slot_q[g] <= dco_word;
    end
  end

  // wr_ptr names the slot due next, which is the older of the two
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_word <= '0;
    else if (hold_entry) hold_word <= slot_q[wr_ptr];
  end

  AST_HOLD_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |=> $stable(hold_word)); // R5
endmodule

// File: rtl/hoc_ctrl.sv
module hoc_ctrl
  import hoc_pkg::*;
#(
  parameter int FW          = 32,
  parameter int PE_W        = 16,
  parameter int LOCK_WIN    = 64,
  parameter int RST_TICKS   = 3000,
  parameter int QUAL_TICKS  = 1000,
  parameter int GRACE_TICKS = 100,
  parameter int SLOT_TICKS  = 2600
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_free,
  input  logic            ref_pick,
  input  logic            ref_bad,
  input  logic            ref_low_rate,
  input  logic [PE_W-1:0] phase_err,
  input  logic [FW-1:0]   dco_word,
  output logic [2:0]      state_o,
  output logic [FW-1:0]   hold_word,
  output logic            capture_pulse,
  output logic            out_en,
  output logic            lock,
  output logic            bw_narrow
);
  hoc_state_e state;
  logic       hold_entry;

  hoc_fsm #(.RST_TICKS(RST_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_free(mode_free), .ref_pick(ref_pick),
    .ref_bad(ref_bad), .state(state), .hold_entry(hold_entry)
  );

  hoc_lock_qual #(
    .PE_W(PE_W), .LOCK_WIN(LOCK_WIN), .QUAL_TICKS(QUAL_TICKS), .GRACE_TICKS(GRACE_TICKS)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .state(state), .phase_err(phase_err), .lock(lock)
  );

  hoc_freq_mem #(.FW(FW), .SLOT_TICKS(SLOT_TICKS)) u_mem (
    .clk(clk), .rst_n(rst_n), .state(state), .lock(lock), .hold_entry(hold_entry),
    .dco_word(dco_word), .hold_word(hold_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bw_narrow <= 1'b0;
    else bw_narrow <= ref_low_rate;
  end

  assign state_o       = state;
  assign capture_pulse = (state == ST_TIE);
  assign out_en        = (state != ST_RESET);
endmodule

// File: tb/hoc_ctrl_tb.sv
`timescale 1ns/1ps
module hoc_ctrl_tb;
  localparam int FW = 16;
  localparam int PE_W = 10;
  localparam int N = 23;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            mode_free, ref_pick, ref_bad, ref_low_rate;
  logic [PE_W-1:0] phase_err;
  logic [FW-1:0]   dco_word;
  logic [2:0]      state_o;
  logic [FW-1:0]   hold_word;
  logic            capture_pulse, out_en, lock, bw_narrow;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  hoc_ctrl #(
    .FW(FW), .PE_W(PE_W), .LOCK_WIN(20), .RST_TICKS(8),
    .QUAL_TICKS(6), .GRACE_TICKS(10), .SLOT_TICKS(16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_free(mode_free), .ref_pick(ref_pick),
    .ref_bad(ref_bad), .ref_low_rate(ref_low_rate), .phase_err(phase_err),
    .dco_word(dco_word), .state_o(state_o), .hold_word(hold_word),
    .capture_pulse(capture_pulse), .out_en(out_en), .lock(lock), .bw_narrow(bw_narrow)
  );

  // {req[3:0], mode_free, ref_pick, ref_bad, phase_err[9:0], cycles[7:0], state[2:0], lock, capture}
  localparam logic [29:0] TBL [N] = '{
    {4'd3,  1'b0,1'b0,1'b0, 10'h000, 8'd1, 3'd4, 1'b0,1'b1}, // R3 holdover -> correction
    {4'd3,  1'b0,1'b0,1'b0, 10'h000, 8'd1, 3'd2, 1'b0,1'b0}, // R3 correction -> normal
    {4'd7,  1'b0,1'b0,1'b0, 10'h000, 8'd5, 3'd2, 1'b0,1'b0}, // R7 still qualifying
    {4'd7,  1'b0,1'b0,1'b0, 10'h000, 8'd1, 3'd2, 1'b1,1'b0}, // R7 lock after 6
    {4'd7,  1'b0,1'b0,1'b0, 10'h019, 8'd1, 3'd2, 1'b0,1'b0}, // R7 excursion +25
    {4'd7,  1'b0,1'b0,1'b0, 10'h3F1, 8'd5, 3'd2, 1'b0,1'b0}, // R7 requalify at -15
    {4'd7,  1'b0,1'b0,1'b0, 10'h3F1, 8'd1, 3'd2, 1'b1,1'b0}, // R7 relocked
    {4'd4,  1'b0,1'b0,1'b1, 10'h000, 8'd1, 3'd3, 1'b1,1'b0}, // R4 disrupted -> holdover
    {4'd6,  1'b0,1'b0,1'b1, 10'h000, 8'd9, 3'd3, 1'b1,1'b0}, // R6 inside grace
    {4'd6,  1'b0,1'b0,1'b1, 10'h000, 8'd1, 3'd3, 1'b0,1'b0}, // R6 grace expired
    {4'd3,  1'b0,1'b0,1'b0, 10'h000, 8'd1, 3'd4, 1'b0,1'b1}, // R3
    {4'd3,  1'b0,1'b0,1'b0, 10'h000, 8'd1, 3'd2, 1'b0,1'b0}, // R3
    {4'd7,  1'b0,1'b0,1'b0, 10'h000, 8'd6, 3'd2, 1'b1,1'b0}, // R7
    {4'd4,  1'b0,1'b1,1'b0, 10'h000, 8'd1, 3'd3, 1'b1,1'b0}, // R4 pick toggle
    {4'd9,  1'b0,1'b1,1'b0, 10'h000, 8'd1, 3'd4, 1'b1,1'b1}, // R9 held pick does not stick
    {4'd10, 1'b0,1'b1,1'b0, 10'h000, 8'd1, 3'd2, 1'b1,1'b0}, // R10 lock kept
    {4'd2,  1'b1,1'b1,1'b0, 10'h000, 8'd1, 3'd1, 1'b0,1'b0}, // R2 freerun, lock low
    {4'd2,  1'b1,1'b1,1'b1, 10'h000, 8'd3, 3'd1, 1'b0,1'b0}, // R2 stays freerun
    {4'd2,  1'b0,1'b1,1'b0, 10'h000, 8'd1, 3'd3, 1'b0,1'b0}, // R2 leave -> holdover
    {4'd3,  1'b0,1'b1,1'b0, 10'h000, 8'd1, 3'd4, 1'b0,1'b1}, // R3
    {4'd3,  1'b0,1'b1,1'b0, 10'h000, 8'd1, 3'd2, 1'b0,1'b0}, // R3
    {4'd7,  1'b0,1'b1,1'b0, 10'h014, 8'd6, 3'd2, 1'b1,1'b0}, // R7 bound 20 is in window
    {4'd7,  1'b0,1'b1,1'b0, 10'h015, 8'd1, 3'd2, 1'b0,1'b0}  // R7 21 is outside
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mode_free = 0; ref_pick = 0; ref_bad = 1; ref_low_rate = 0;
    phase_err = '0; dco_word = '0;
    do_reset();
    chk("R1 state in reset", 32'(state_o), 0);
    chk("R1 out_en in reset", 32'(out_en), 0);
    chk("R1 lock in reset", 32'(lock), 0);
    rst_n = 1'b1;
    step(7);
    chk("R1 still reset after 7", 32'(state_o), 0);
    chk("R1 out_en low after 7", 32'(out_en), 0);
    step(1);
    chk("R1 holdover after 8", 32'(state_o), 3);
    chk("R1 out_en high", 32'(out_en), 1);

    for (int i = 0; i < N; i++) begin
      logic [29:0] r;
      r = TBL[i];
      mode_free = r[25];
      ref_pick  = r[24];
      ref_bad   = r[23];
      phase_err = r[22:13];
      step(int'(r[12:5]));
      total++;
      if (state_o !== r[4:2] || lock !== r[1] || capture_pulse !== r[0]) begin
        bad++;
        $display("FAIL R%0d row %0d act=st%0d/lk%0d/cp%0d exp=st%0d/lk%0d/cp%0d",
                 r[29:26], i, state_o, lock, capture_pulse, r[4:2], r[1], r[0]);
      end
    end

    ref_low_rate = 1'b1;
    step(1);
    chk("R8 narrow bandwidth", 32'(bw_narrow), 1);
    ref_low_rate = 1'b0;
    step(1);
    chk("R8 wide bandwidth", 32'(bw_narrow), 0);

    // R5: older slot chosen on holdover entry
    mode_free = 0; ref_pick = 0; ref_bad = 0; phase_err = '0;
    do_reset();
    rst_n = 1'b1;
    step(8);
    step(1);
    step(1);
    chk("R5 normal before sampling", 32'(state_o), 2);
    step(6);
    chk("R5 locked before sampling", 32'(lock), 1);
    dco_word = 16'h1111;
    step(16);
    dco_word = 16'h2222;
    step(16);
    dco_word = 16'h3333;
    step(16);
    dco_word = 16'h4444;
    step(5);
    ref_bad = 1'b1;
    step(1);
    chk("R5 holdover entered", 32'(state_o), 3);
    chk("R5 older slot used", 32'(hold_word), 32'h2222);
    dco_word = 16'h5555;
    step(3);
    chk("R5 hold word steady", 32'(hold_word), 32'h2222);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule